// File: doc/BRIEF.md
# Half-Duplex RS-485 Byte Controller

This block moves bytes over a two-wire half-duplex RS-485 link through an external transceiver. It serialises each byte handed over by the host as an asynchronous frame and owns the transceiver's drive-enable line. Drive-enable rises a full bit time before each start bit and drops only once the stop bit has left the line. When the controller is not driving, it watches the bus for frames from other nodes. It samples each bit at its centre, using sixteen oversampling ticks per bit, and hands each decoded byte to the host with a framing-error flag.

A self-test input keeps the transceiver's receiver enabled while the controller drives. Each byte read back from the bus is compared against the byte that was sent. A wrong echo, or no echo at all, raises a one-cycle fault strobe, which exposes broken wiring, a dead transceiver or a shorted pair. Outside self-test, anything heard while driving is dropped. Bytes heard while driving are never handed to the host, in either mode.

Top module: `rs485_uart_hd`

## Requirements
- R1: After reset, dir_de is low, line_tx is high, tx_ready is high, rx_en is high, and rx_valid, echo_mismatch and echo_missing are low.
- R2: A transmitted frame is one low start bit, then eight data bits with the least significant bit first, then one high stop bit. Every bit lasts 16*(baud_div+1) clock cycles.
- R3: dir_de rises at least one bit time before the falling edge of the start bit. When no further byte is waiting, it falls within one clock after the stop bit ends and never before.
- R4: If tx_valid is held with a new byte when a stop bit ends, that byte is accepted, dir_de stays high and the next start bit follows the stop bit with no gap.
- R5: line_tx is high whenever dir_de is low. Outside self-test, rx_en is low while dir_de is high.
- R6: A received frame whose start bit is still low at mid-bit is decoded by sampling each bit at its centre. The byte appears on rx_data with a one-cycle rx_valid pulse.
- R7: A low pulse on an idle line_rx shorter than half a bit time does not start a frame and produces no rx_valid.
- R8: If line_rx is low at the centre of the stop bit, the byte is still delivered and rx_frame_err is high with that rx_valid pulse. Otherwise rx_frame_err is low.
- R9: Outside self-test, a frame heard while dir_de was high at any point in it is discarded and produces no rx_valid.
- R10: In self-test, rx_en stays high while driving. A correct echo of each sent byte raises no fault, and echoes are not presented on rx_valid.
- R11: In self-test, an echo byte that differs from the sent byte, or that has a low stop bit, produces a one-cycle echo_mismatch pulse.
- R12: In self-test, if no echo arrives, echo_missing pulses once, after dir_de falls and no more than ten bit times later.
- R13: A byte is taken on a clock where tx_valid and tx_ready are both high. tx_ready is then low until the clock that ends that frame's stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | DIV_W | Oversample tick period minus one, in clocks |
| self_test | input | 1 | Keep receiver on while driving and check echoes |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data holds a byte to send |
| tx_ready | output | 1 | Controller accepts a byte this cycle |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| rx_frame_err | output | 1 | Stop bit was low for the strobed byte |
| echo_mismatch | output | 1 | Self-test echo differed from sent byte |
| echo_missing | output | 1 | Self-test echo never arrived |
| line_tx | output | 1 | Data to transceiver driver input |
| line_rx | input | 1 | Data from transceiver receiver output |
| dir_de | output | 1 | Transceiver driver enable |
| rx_en | output | 1 | Transceiver receiver enable, active high |

## Verification
The bench measures the gap between the rise of drive-enable and the start edge. This catches a design that starts shifting at once, which would lose the first bit to the transceiver's turn-on. It sends two back-to-back bytes and checks that drive-enable neither dips nor leaves a gap between them: a design that releases the bus between frames would let another node collide. It injects a short glitch on the idle line, holds a stop bit low, and loops the driver onto the receiver. A wrong design would then decode phantom bytes, miss the framing flag or hand its own echo to the host. In self-test, it corrupts one echoed data bit and, separately, holds the bus high so that no echo arrives. It checks that exactly the right fault strobe appears, in the right window after the bus is released.

// File: rtl/rs485_uart_hd.sv
module rs485_uart_hd #(
  parameter int DIV_W     = 16,
  parameter int OSR       = 16,
  parameter int ECHO_BITS = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             self_test,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_frame_err,
  output logic             echo_mismatch,
  output logic             echo_missing,
  output logic             line_tx,
  input  logic             line_rx,
  output logic             dir_de,
  output logic             rx_en
);
  localparam int CNT_W      = $clog2(OSR + 1);
  localparam int ECHO_TICKS = OSR * ECHO_BITS;
  localparam int EW         = $clog2(ECHO_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LEAD_C = CNT_W'(OSR);
  localparam logic [EW-1:0]    ECHO_C = EW'(ECHO_TICKS - 1);

  typedef enum logic [2:0] {T_IDLE, T_LEAD, T_START, T_DATA, T_STOP} tx_st_t;
  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_st_t;

  logic [DIV_W-1:0] pcnt;
  logic             tick;
  assign tick = (pcnt == baud_div);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pcnt <= '0;
    else        pcnt <= tick ? '0 : pcnt + 1'b1;

  logic [1:0] rsync;
  logic       rxs;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rsync <= 2'b11;
    else        rsync <= {rsync[0], line_rx};
  assign rxs = rsync[1];

  tx_st_t           ts;
  logic [CNT_W-1:0] tcnt;
  logic [2:0]       tbit;
  logic [7:0]       tsh;
  logic             tbit_end, tx_take;

  assign tbit_end = tick && (tcnt == LAST_C);
  assign tx_ready = (ts == T_IDLE) || (ts == T_STOP && tbit_end);
  assign tx_take  = tx_valid && tx_ready;
  assign dir_de   = (ts != T_IDLE);
  assign line_tx  = (ts == T_START) ? 1'b0 : (ts == T_DATA) ? tsh[0] : 1'b1;
  assign rx_en    = self_test || !dir_de;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts   <= T_IDLE;
      tcnt <= '0;
      tbit <= '0;
      tsh  <= '0;
    end else begin
      case (ts)
        T_IDLE: if (tx_take) begin
          ts   <= T_LEAD;
          tcnt <= '0;
          tsh  <= tx_data;
        end
        T_LEAD: if (tick) begin
          if (tcnt == LEAD_C) begin
            ts   <= T_START;
            tcnt <= '0;
          end else tcnt <= tcnt + 1'b1;
        end
        default: begin
          if (tick) tcnt <= tbit_end ? '0 : tcnt + 1'b1;
          if (tbit_end) begin
            case (ts)
              T_START: begin
                ts   <= T_DATA;
                tbit <= '0;
              end
              T_DATA: begin
                tsh  <= {1'b1, tsh[7:1]};
                tbit <= tbit + 1'b1;
                if (tbit == 3'd7) ts <= T_STOP;
              end
              default: begin
                if (tx_valid) begin
                  ts  <= T_START;
                  tsh <= tx_data;
                end else ts <= T_IDLE;
              end
            endcase
          end
        end
      endcase
    end
  end

  rx_st_t           rs;
  logic [CNT_W-1:0] rcnt;
  logic [2:0]       rbit;
  logic [7:0]       rsh;
  logic             rflag, rbit_end, rhalf, rdone, heard_drive;

  assign rbit_end    = tick && (rcnt == LAST_C);
  assign rhalf       = tick && (rcnt == HALF_C);
  assign rdone       = (rs == R_STOP) && rbit_end;
  assign heard_drive = rflag || dir_de;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs    <= R_IDLE;
      rcnt  <= '0;
      rbit  <= '0;
      rsh   <= '0;
      rflag <= 1'b0;
    end else begin
      rflag <= (rs == R_IDLE) ? dir_de : heard_drive;
      case (rs)
        R_IDLE: if (!rxs) begin
          rs   <= R_START;
          rcnt <= '0;
        end
        R_START: if (tick) begin
          if (rhalf) begin
            rs   <= rxs ? R_IDLE : R_DATA;
            rcnt <= '0;
            rbit <= '0;
          end else rcnt <= rcnt + 1'b1;
        end
        R_DATA: if (tick) begin
          rcnt <= rbit_end ? '0 : rcnt + 1'b1;
          if (rbit_end) begin
            rsh  <= {rxs, rsh[7:1]};
            rbit <= rbit + 1'b1;
            if (rbit == 3'd7) rs <= R_STOP;
          end
        end
        default: if (tick) begin
          rcnt <= rbit_end ? '0 : rcnt + 1'b1;
          if (rbit_end) rs <= R_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid     <= 1'b0;
      rx_data      <= '0;
      rx_frame_err <= 1'b0;
    end else begin
      rx_valid <= rdone && !heard_drive;
      if (rdone && !heard_drive) begin
        rx_data      <= rsh;
        rx_frame_err <= !rxs;
      end
    end
  end

  logic          pend;
  logic [EW-1:0] ecnt;
  logic [7:0]    sent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend          <= 1'b0;
      ecnt          <= '0;
      sent          <= '0;
      echo_mismatch <= 1'b0;
      echo_missing  <= 1'b0;
    end else begin
      echo_mismatch <= 1'b0;
      echo_missing  <= 1'b0;
      if (tx_take) begin
        echo_missing <= pend;
        pend         <= self_test;
        ecnt         <= '0;
        sent         <= tx_data;
      end else if (rdone && heard_drive && pend) begin
        echo_mismatch <= (rsh != sent) || !rxs;
        pend          <= 1'b0;
      end else if (pend && tick) begin
        if (ecnt == ECHO_C) begin
          echo_missing <= 1'b1;
          pend         <= 1'b0;
        end else ecnt <= ecnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs485_uart_hd_chk.sv
module rs485_uart_hd_chk (
  input logic clk,
  input logic rst_n,
  input logic dir_de,
  input logic line_tx,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic echo_mismatch,
  input logic echo_missing
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_de |-> line_tx); // R5
  AST_START_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_tx) |-> dir_de); // R5
  AST_DIR_RISE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir_de) |-> line_tx); // R3
  AST_DIR_FALL_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dir_de) |-> line_tx && $past(line_tx)); // R3
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready); // R13
  AST_RX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R6
  AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({echo_mismatch, echo_missing})); // R11
endmodule

bind rs485_uart_hd rs485_uart_hd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dir_de(dir_de), .line_tx(line_tx),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .echo_mismatch(echo_mismatch), .echo_missing(echo_missing)
);

// File: tb/rs485_uart_hd_bench.sv
module rs485_uart_hd_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV    = 3;
  localparam int BITCLK = 16 * (DIV + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] baud_div = 16'(DIV);
  logic        self_test = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_valid = 1'b0;
  logic        tx_ready, rx_valid, rx_frame_err, echo_mismatch, echo_missing;
  logic        line_tx, line_rx, dir_de, rx_en;
  logic [7:0]  rx_data;

  logic lmode = 1'b1;
  logic bus_drv = 1'b1;
  logic force_lo = 1'b0;
  assign line_rx = lmode ? bus_drv : (line_tx & ~force_lo);

  always #(CLK_PERIOD/2) clk = ~clk;

  rs485_uart_hd u_rs485_uart_hd (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .self_test(self_test),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
    .echo_mismatch(echo_mismatch), .echo_missing(echo_missing),
    .line_tx(line_tx), .line_rx(line_rx), .dir_de(dir_de), .rx_en(rx_en)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int rise_cyc = 0, fall_cyc = 0, miss_cyc = 0;
  int rx_seen = 0, mism_n = 0, miss_n = 0;
  logic prev_dir = 1'b0;
  logic [8:0] rx_exp[$];
  logic [7:0] tx_exp[$];
  bit done = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (dir_de && !prev_dir) rise_cyc = cyc;
    if (!dir_de && prev_dir) fall_cyc = cyc;
    prev_dir = dir_de;
    if (echo_mismatch) mism_n++;
    if (echo_missing) begin miss_n++; miss_cyc = cyc; end
    if (rx_valid) begin
      rx_seen++;
      if (rx_exp.size() == 0) check("R9 unexpected rx byte", {23'd0, rx_frame_err, rx_data}, 32'h1ff);
      else begin
        logic [8:0] e;
        e = rx_exp.pop_front();
        check("R6 rx data", {24'd0, rx_data}, {24'd0, e[7:0]});
        check("R8 rx frame error flag", {31'd0, rx_frame_err}, {31'd0, e[8]});
      end
    end
  end

  task automatic decode_frame(output bit again);
    logic [7:0] got;
    check("R3 lead time", int'((cyc - rise_cyc) >= BITCLK), 1);
    repeat (BITCLK/2) @(negedge clk);
    check("R2 start bit low", {31'd0, line_tx}, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (BITCLK) @(negedge clk);
      got[i] = line_tx;
    end
    repeat (BITCLK) @(negedge clk);
    check("R2 stop bit high", {31'd0, line_tx}, 1);
    if (tx_exp.size() == 0) check("R2 unexpected frame", {24'd0, got}, 32'h1ff);
    else check("R2 tx byte lsb first", {24'd0, got}, {24'd0, tx_exp.pop_front()});
    repeat (BITCLK/2 - 1) @(negedge clk);
    check("R3 dir held through stop", {31'd0, dir_de}, 1);
    @(negedge clk);
    if (tx_exp.size() > 0) begin
      check("R4 dir stays high between frames", {31'd0, dir_de}, 1);
      check("R4 next start without gap", {31'd0, line_tx}, 0);
    end else
      check("R3 dir released after stop", {31'd0, dir_de}, 0);
    again = dir_de && !line_tx;
  endtask

  initial begin
    logic prev_tx;
    bit again;
    prev_tx = 1'b1;
    forever begin
      @(negedge clk);
      if (prev_tx && !line_tx) begin
        do decode_frame(again); while (again);
      end
      prev_tx = line_tx;
    end
  end

  task automatic send(input logic [7:0] b, input bit keep);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = b;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    tx_exp.push_back(b);
    @(negedge clk);
    check("R13 ready low after take", {31'd0, tx_ready}, 0);
    if (!keep) tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (dir_de) @(negedge clk);
    repeat (2*BITCLK) @(negedge clk);
  endtask

  task automatic drive_frame(input logic [7:0] b, input bit stop_ok);
    rx_exp.push_back({!stop_ok, b});
    lmode = 1'b1;
    @(negedge clk);
    bus_drv = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      bus_drv = b[i];
      repeat (BITCLK) @(negedge clk);
    end
    if (stop_ok) begin
      bus_drv = 1'b1;
      repeat (BITCLK) @(negedge clk);
    end else begin
      bus_drv = 1'b0;
      repeat (BITCLK*10/16) @(negedge clk);
      bus_drv = 1'b1;
      repeat (BITCLK - BITCLK*10/16) @(negedge clk);
    end
    repeat (2*BITCLK) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check("R1 dir low", {31'd0, dir_de}, 0);
    check("R1 line high", {31'd0, line_tx}, 1);
    check("R1 ready high", {31'd0, tx_ready}, 1);
    check("R1 rx_en high", {31'd0, rx_en}, 1);
    check("R1 strobes low", {29'd0, rx_valid, echo_mismatch, echo_missing}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    send(8'hA5, 1'b0);
    check("R5 receiver off while driving", {31'd0, rx_en}, 0);
    wait_idle();

    send(8'h01, 1'b1);
    send(8'h03, 1'b0);
    wait_idle();

    base = rx_seen;
    lmode = 1'b0;
    send(8'h3C, 1'b0);
    wait_idle();
    check("R9 own frame discarded", rx_seen, base);

    drive_frame(8'h96, 1'b1);
    drive_frame(8'h00, 1'b1);
    drive_frame(8'hFF, 1'b1);
    check("R6 three bytes received", rx_seen, base + 3);
    drive_frame(8'h5A, 1'b0);
    check("R8 errored byte delivered", rx_seen, base + 4);

    base = rx_seen;
    bus_drv = 1'b0;
    repeat (BITCLK/4) @(negedge clk);
    bus_drv = 1'b1;
    repeat (3*BITCLK) @(negedge clk);
    check("R7 glitch rejected", rx_seen, base);

    self_test = 1'b1;
    lmode = 1'b0;
    send(8'hC3, 1'b0);
    repeat (4) @(negedge clk);
    check("R10 receiver on while driving", {31'd0, rx_en & dir_de}, 1);
    wait_idle();
    repeat (10*BITCLK) @(negedge clk);
    check("R10 clean echo no mismatch", mism_n, 0);
    check("R10 clean echo no missing", miss_n, 0);
    check("R10 echo not presented", rx_seen, base);

    send(8'hFF, 1'b0);
    while (line_tx) @(negedge clk);
    repeat (3*BITCLK) @(negedge clk);
    force_lo = 1'b1;
    repeat (BITCLK) @(negedge clk);
    force_lo = 1'b0;
    wait_idle();
    check("R11 mismatch reported", mism_n, 1);
    check("R11 no missing on mismatch", miss_n, 0);

    lmode = 1'b1;
    bus_drv = 1'b1;
    send(8'h55, 1'b0);
    wait_idle();
    repeat (12*BITCLK) @(negedge clk);
    check("R12 missing reported once", miss_n, 1);
    check("R12 missing window", int'((miss_cyc > fall_cyc) && (miss_cyc - fall_cyc <= 10*BITCLK + 8)), 1);
    check("R12 no mismatch", mism_n, 1);
    check("R12 nothing presented", rx_seen, base);

    finish_run();
  end
endmodule